// File: doc/BRIEF.md
# SPI Mode-Fault Protection Controller

This block guards the pad drivers of an SPI port that can run as either master or slave. It holds the port's master-select, enable and interrupt-enable control bits. It also watches the slave-select input through a synchronizer. If the port is a master and some other device pulls slave-select low, the block concludes that a second master is on the bus. It then turns every SPI pad into an input at once, and it clears the master-select and enable bits in hardware. Finally it sets a sticky mode-fault flag, which can raise an interrupt.

Software recovers in two steps. First it reads the status register while the flag is set, and then it writes the control register. The pads stay forced to inputs until a control write sets the enable bit again. When the slave-select pin is used as a general-purpose pin, fault detection is off.

Top module: `spi_mfault_guard`

## Requirements
- R1: After reset, the mode-fault flag, interrupt request, master-select, enable and interrupt-enable bits all read 0, and `pad_oe` equals `gpio_dir`.
- R2: A fault is detected only while the master-select bit is 1, the synchronized slave-select is 0 and `ss_gpio_sel` is 0. A port with master-select 0 never sets the flag.
- R3: The slave-select pin passes through SYNC_STAGES flops (default 2). A fault raised by a falling pin therefore sets the flag on the third rising clock edge after the change, and not on the second.
- R4: On the edge where a fault is taken, the master-select and enable bits become 0, whatever value a control write in the same cycle carries.
- R5: From a fault onward, all three `pad_oe` bits are 0 whatever `gpio_dir` holds. This lock ends only on a control write with the enable bit 1 in a cycle without a new fault.
- R6: `irq` is 1 exactly when the mode-fault flag and the interrupt-enable bit are both 1.
- R7: The flag clears only on a control write that follows a status read made while the flag was set. A write with no such read leaves the flag set, and a status read made while the flag is clear does not count.
- R8: A fault detected in the same cycle as a clearing control write wins: the flag stays 1 and the master-select and enable bits become 0.
- R9: While `ss_gpio_sel` is 1, the flag never becomes set, even with master-select 1 and slave-select low.
- R10: Pad bit positions are `pad_oe[0]`=SCK, `[1]`=MOSI and `[2]`=MISO. Without the lock, enable 0 gives `pad_oe = gpio_dir`. Enable 1 with master 1 gives 3'b011. Enable 1 with master 0 gives 3'b100 while the synchronized slave-select is low, and 3'b000 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n_pin | input | 1 | Asynchronous slave-select pin, active low |
| ss_gpio_sel | input | 1 | 1 = slave-select pin used as general-purpose pin; detection off |
| gpio_dir | input | 3 | General-purpose direction per pad (1 = output) |
| sts_rd | input | 1 | Status register read strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wr_master | input | 1 | Master-select value written |
| ctl_wr_enable | input | 1 | Enable value written |
| ctl_wr_irq_en | input | 1 | Interrupt-enable value written |
| pad_oe | output | 3 | Pad output enables: [0] SCK, [1] MOSI, [2] MISO |
| master_q | output | 1 | Current master-select bit |
| enable_q | output | 1 | Current enable bit |
| irq_en_q | output | 1 | Current interrupt-enable bit |
| mode_fault | output | 1 | Sticky mode-fault flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobes `sts_rd` and `ctl_wr` are synchronous one-cycle pulses. They also assume that `ss_gpio_sel` and the written data are steady around the clock edge, and that only `ss_n_pin` may change at any time. The stimulus drives every input, the pin included, on the falling clock edge. It raises each strobe for exactly one cycle. It places the coincident fault-and-write case by counting the synchronizer delay, so the write lands in the cycle where detection is active. Every mode and configuration is swept from a fresh reset, so each case starts from a known lock and arm state.

// File: rtl/spi_mfg_pkg.sv
package spi_mfg_pkg;
   localparam int unsigned PAD_CNT  = 3;
   localparam int unsigned PAD_SCK  = 0;
   localparam int unsigned PAD_MOSI = 1;
   localparam int unsigned PAD_MISO = 2;

   typedef struct packed {
      logic master;
      logic enable;
      logic irq_en;
   } spi_ctl_t;
endpackage

// File: rtl/spi_mfg_sync.sv
module spi_mfg_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_mfg_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];

   AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_q[STAGES-2] != q_sync) |=> (q_sync == $past(chain_q[STAGES-2]))); // R3
endmodule

// File: rtl/spi_mfg_ctrl.sv
module spi_mfg_ctrl
   import spi_mfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ss_sync,
   input  logic     ss_gpio_sel,
   input  logic     sts_rd,
   input  logic     ctl_wr,
   input  spi_ctl_t ctl_wdata,
   output spi_ctl_t ctl_q,
   output logic     fault_flag,
   output logic     pad_lock
);
   logic fault_det;
   logic rd_armed;

   assign fault_det = ctl_q.master & ~ss_sync & ~ss_gpio_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (fault_det) begin
         ctl_q.master <= 1'b0;
         ctl_q.enable <= 1'b0;
         if (ctl_wr) ctl_q.irq_en <= ctl_wdata.irq_en;
      end else if (ctl_wr) begin
         ctl_q <= ctl_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_flag <= 1'b0;
         rd_armed   <= 1'b0;
      end else if (fault_det) begin
         fault_flag <= 1'b1;
         rd_armed   <= 1'b0;
      end else if (ctl_wr && rd_armed) begin
         fault_flag <= 1'b0;
         rd_armed   <= 1'b0;
      end else if (sts_rd && fault_flag) begin
         rd_armed   <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pad_lock <= 1'b0;
      else if (fault_det)                 pad_lock <= 1'b1;
      else if (ctl_wr && ctl_wdata.enable) pad_lock <= 1'b0;
   end

   AST_SLAVE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.master |=> !$rose(fault_flag)); // R2
   AST_GPIO_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      ss_gpio_sel |=> !$rose(fault_flag)); // R9
   AST_FAULT_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag) |-> (!ctl_q.master && !ctl_q.enable && pad_lock)); // R4
   AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_flag) |-> ($past(ctl_wr) && $past(rd_armed))); // R7
   AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pad_lock) |-> ($past(ctl_wr) && $past(ctl_wdata.enable))); // R5
endmodule

// File: rtl/spi_mfg_pads.sv
module spi_mfg_pads
   import spi_mfg_pkg::*;
(
   input  logic               lock,
   input  spi_ctl_t           ctl,
   input  logic               ss_sync,
   input  logic [PAD_CNT-1:0] gpio_dir,
   output logic [PAD_CNT-1:0] pad_oe
);
   logic [PAD_CNT-1:0] spi_dir;

   for (genvar p = 0; p < PAD_CNT; p++) begin : g_pad
      if (p == PAD_MISO) begin : g_slave_out
         assign spi_dir[p] = ~ctl.master & ~ss_sync;
      end else begin : g_master_out
         assign spi_dir[p] = ctl.master;
      end
      assign pad_oe[p] = lock ? 1'b0 : (ctl.enable ? spi_dir[p] : gpio_dir[p]);
   end

   always_comb begin
      AST_ONE_DRIVER_SET: assert (!(pad_oe[PAD_MISO] && pad_oe[PAD_SCK] && ctl.enable)); // R10
   end
endmodule

// File: rtl/spi_mfault_guard.sv
module spi_mfault_guard
   import spi_mfg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ss_n_pin,
   input  logic               ss_gpio_sel,
   input  logic [PAD_CNT-1:0] gpio_dir,
   input  logic               sts_rd,
   input  logic               ctl_wr,
   input  logic               ctl_wr_master,
   input  logic               ctl_wr_enable,
   input  logic               ctl_wr_irq_en,
   output logic [PAD_CNT-1:0] pad_oe,
   output logic               master_q,
   output logic               enable_q,
   output logic               irq_en_q,
   output logic               mode_fault,
   output logic               irq
);
   logic     ss_sync;
   logic     lock;
   spi_ctl_t wdata;
   spi_ctl_t ctl;

   assign wdata = '{master: ctl_wr_master, enable: ctl_wr_enable, irq_en: ctl_wr_irq_en};

   spi_mfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(ss_n_pin), .q_sync(ss_sync)
   );

   spi_mfg_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .ss_sync(ss_sync), .ss_gpio_sel(ss_gpio_sel),
      .sts_rd(sts_rd), .ctl_wr(ctl_wr), .ctl_wdata(wdata),
      .ctl_q(ctl), .fault_flag(mode_fault), .pad_lock(lock)
   );

   spi_mfg_pads u_pads (
      .lock(lock), .ctl(ctl), .ss_sync(ss_sync), .gpio_dir(gpio_dir), .pad_oe(pad_oe)
   );

   assign master_q = ctl.master;
   assign enable_q = ctl.enable;
   assign irq_en_q = ctl.irq_en;
   assign irq      = mode_fault & ctl.irq_en;

   AST_FAULT_PADS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_fault) |-> (pad_oe == '0)); // R5
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mode_fault && irq_en_q)); // R6
endmodule

// File: tb/spi_mfault_guard_tb.sv
module spi_mfault_guard_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ss_n_pin = 1'b1;
   logic       ss_gpio_sel = 1'b0;
   logic [2:0] gpio_dir = 3'b000;
   logic       sts_rd = 1'b0;
   logic       ctl_wr = 1'b0;
   logic       ctl_wr_master = 1'b0;
   logic       ctl_wr_enable = 1'b0;
   logic       ctl_wr_irq_en = 1'b0;
   logic [2:0] pad_oe;
   logic       master_q, enable_q, irq_en_q, mode_fault, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_mfault_guard u_dut (
      .clk(clk), .rst_n(rst_n), .ss_n_pin(ss_n_pin), .ss_gpio_sel(ss_gpio_sel),
      .gpio_dir(gpio_dir), .sts_rd(sts_rd), .ctl_wr(ctl_wr),
      .ctl_wr_master(ctl_wr_master), .ctl_wr_enable(ctl_wr_enable),
      .ctl_wr_irq_en(ctl_wr_irq_en), .pad_oe(pad_oe), .master_q(master_q),
      .enable_q(enable_q), .irq_en_q(irq_en_q), .mode_fault(mode_fault), .irq(irq)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ss_n_pin = 1'b1; sts_rd = 1'b0; ctl_wr = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic wr(input logic m, input logic e, input logic ie);
      ctl_wr = 1'b1; ctl_wr_master = m; ctl_wr_enable = e; ctl_wr_irq_en = ie;
      step(1);
      ctl_wr = 1'b0;
   endtask

   task automatic rd();
      sts_rd = 1'b1;
      step(1);
      sts_rd = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      gpio_dir = 3'b101;
      do_reset();
      // R1 reset state
      check("R1 flag", mode_fault, 0);
      check("R1 irq", irq, 0);
      check("R1 ctl", {master_q, enable_q, irq_en_q}, 0);
      check("R1 pads", pad_oe, 3'b101);

      // R2 R3 R4 R5 R6 R9 sweep
      for (int cfg = 0; cfg < 16; cfg++) begin
         logic m, g, e, ie, flt;
         m = cfg[0]; g = cfg[1]; e = cfg[2]; ie = cfg[3];
         flt = m & ~g;
         do_reset();
         ss_gpio_sel = g; gpio_dir = 3'b111;
         wr(m, e, ie);
         ss_n_pin = 1'b0;
         step(2);
         check("R3 not yet", mode_fault, 0);
         step(1);
         check(g ? "R9 gpio" : "R2 detect", mode_fault, flt);
         check("R6 irq", irq, flt & ie);
         if (flt) begin
            check("R4 forced", {master_q, enable_q}, 0);
            check("R5 pads in", pad_oe, 0);
         end else begin
            check("R2 ctl kept", {master_q, enable_q}, {m, e});
         end
         ss_n_pin = 1'b1;
         ss_gpio_sel = 1'b0;
      end

      // R7 clear sequence, R5 lock release
      do_reset();
      gpio_dir = 3'b111;
      wr(1, 1, 1);
      ss_n_pin = 1'b0; step(3); ss_n_pin = 1'b1; step(2);
      check("R7 set", mode_fault, 1);
      wr(0, 0, 1);
      check("R7 write without read", mode_fault, 1);
      check("R5 still locked", pad_oe, 0);
      rd();
      check("R7 read alone", mode_fault, 1);
      wr(0, 0, 1);
      check("R7 cleared", mode_fault, 0);
      check("R6 irq low", irq, 0);
      check("R5 lock after enable0", pad_oe, 0);
      wr(1, 1, 0);
      check("R5 released", pad_oe, 3'b011);

      // R7 read while clear does not arm
      do_reset();
      rd();
      wr(1, 1, 0);
      ss_n_pin = 1'b0; step(3); ss_n_pin = 1'b1; step(2);
      check("R7 fault", mode_fault, 1);
      wr(0, 0, 0);
      check("R7 stale read", mode_fault, 1);

      // R8 fault coincident with clearing write
      do_reset();
      wr(1, 0, 0);
      ss_n_pin = 1'b0; step(3); ss_n_pin = 1'b1; step(2);
      wr(1, 1, 0);
      check("R8 pre flag", mode_fault, 1);
      rd();
      ss_n_pin = 1'b0;
      step(2);
      wr(1, 1, 0);
      check("R8 flag kept", mode_fault, 1);
      check("R8 ctl forced", {master_q, enable_q}, 0);
      check("R8 pads", pad_oe, 0);
      ss_n_pin = 1'b1;

      // R10 pad direction sweep (detection off)
      do_reset();
      ss_gpio_sel = 1'b1;
      for (int v = 0; v < 64; v++) begin
         logic [2:0] dir, exp;
         logic m, e, sl;
         dir = v[2:0]; m = v[3]; e = v[4]; sl = v[5];
         gpio_dir = dir;
         wr(m, e, 0);
         ss_n_pin = ~sl;
         step(3);
         exp = !e ? dir : (m ? 3'b011 : (sl ? 3'b100 : 3'b000));
         check("R10 pads", pad_oe, exp);
      end
      ss_gpio_sel = 1'b0;
      ss_n_pin = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule